// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures an intermediate frequency by counting rising edges of a pre-synchronised IF signal over a gate window of fixed length. The window is timed by a 50 kHz reference tick, which arrives as a one-cycle enable on the system clock. The window lasts 100, 200, 400 or 1000 ticks, which is 2, 4, 8 or 20 ms. In FM mode the edges first pass through a prescaler that divides by 2 or by 4. In AM mode every edge goes straight to the counter.

Once enabled, the block waits a short start-up delay of five reference ticks. It then runs gate windows back to back. Each window counts up from zero, and its final count is latched into a result register when the window closes. A one-cycle valid strobe marks each load. A count that does not fit the register saturates at all-ones and raises an overflow flag that travels with that result. Gate length and prescaler settings are captured when a window opens. Clearing the enable stops the measurement and leaves the last result in place.

Top module: `if_gate_counter`

## Requirements
- R1: After reset, `result` is 0, `result_valid` is 0 and `overflow` is 0.
- R2: The gate lasts 100, 200, 400 or 1000 reference ticks for `gate_sel` = 00, 01, 10, 11. Consecutive `result_valid` strobes are spaced by exactly that many ticks.
- R3: With `fm_mode`=1, the loaded count is floor(E/2) when `pre_sel`=0 and floor(E/4) when `pre_sel`=1. E is the number of rising edges in the window. The prescaler restarts at each window opening.
- R4: With `fm_mode`=0, every rising edge of `if_in` inside the window adds one to the count. A rising edge is a low sample followed by a high sample on consecutive clocks.
- R5: `result_valid` is high for exactly one clock per load. `result` does not change in any other cycle.
- R6: Windows repeat continuously while enabled, and each window counts from zero. A window with no edges yields 0 even after a non-zero window.
- R7: After `enable` rises, the first strobe appears after 5 start-up ticks plus one gate length. With a tick on every clock, it is observed on the (len+6)-th falling edge after the enabling rising edge.
- R8: A count above 2^CNT_W−1 loads all-ones with `overflow`=1. `overflow` is reloaded with each result and returns to 0 on the next result that fits.
- R9: `gate_sel`, `pre_sel` and `fm_mode` are sampled when a window opens. A change during a window applies from the next window.
- R10: While `enable` is 0, no strobe occurs and `result` keeps its last value. Re-enabling restarts the start-up delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle 50 kHz reference tick |
| if_in | input | 1 | IF signal, already synchronised to clk |
| enable | input | 1 | Measurement enable |
| fm_mode | input | 1 | 1 = FM (prescaler used), 0 = AM |
| gate_sel | input | 2 | Gate length select |
| pre_sel | input | 1 | FM prescaler: 0 = divide by 2, 1 = divide by 4 |
| result | output | CNT_W | Latched count of the last window |
| result_valid | output | 1 | One-cycle strobe on each result load |
| overflow | output | 1 | Last result saturated |

## Verification
A wrong gate-tick counter or length decode shows up as strobe spacing that differs from the tick count. This appears within one window after the configuration is captured. A prescaler that is left in a stale phase, or a data counter that is not cleared at window opening, gives a wrong result on the very next strobe. Placing a known burst of edges well inside a window makes that result exact. Faults in start-up sequencing or in handling the enable show as a misplaced first strobe, or as a strobe or result change while the block is disabled, within a gate length plus five ticks.

// File: rtl/if_gate_counter.sv
module if_gate_counter #(
  parameter int CNT_W         = 16,
  parameter int STARTUP_TICKS = 5,
  parameter int GATE_T0       = 100,
  parameter int GATE_T1       = 200,
  parameter int GATE_T2       = 400,
  parameter int GATE_T3       = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             if_in,
  input  logic             enable,
  input  logic             fm_mode,
  input  logic [1:0]       gate_sel,
  input  logic             pre_sel,
  output logic [CNT_W-1:0] result,
  output logic             result_valid,
  output logic             overflow
);
  localparam int TW = $clog2(GATE_T3 + 1);
  localparam int SW = $clog2(STARTUP_TICKS + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_GATE} st_t;
  st_t st;

  logic [SW-1:0]    scnt;
  logic [TW-1:0]    tcnt, tlen, sel_len;
  logic             fm_q, div4_q, if_q, sat;
  logic [1:0]       pcnt;
  logic [CNT_W-1:0] dcnt;

  always_comb
    case (gate_sel)
      2'b00:   sel_len = TW'(GATE_T0);
      2'b01:   sel_len = TW'(GATE_T1);
      2'b10:   sel_len = TW'(GATE_T2);
      default: sel_len = TW'(GATE_T3);
    endcase

  logic             rise, pulse, full, snext, close, open_now;
  logic [1:0]       pmax;
  logic [CNT_W-1:0] dnext;

  assign rise     = if_in & ~if_q;
  assign pmax     = div4_q ? 2'd3 : 2'd1;
  assign pulse    = (st == S_GATE) && rise && (!fm_q || pcnt == pmax);
  assign full     = &dcnt;
  assign dnext    = (pulse && !full) ? dcnt + 1'b1 : dcnt;
  assign snext    = sat | (pulse & full);
  assign close    = (st == S_GATE) && ref_tick && (tcnt == tlen - 1'b1);
  assign open_now = close ||
                    ((st == S_WAIT) && ref_tick && (scnt == SW'(STARTUP_TICKS - 1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; scnt <= '0; tcnt <= '0; tlen <= '0;
      fm_q <= 1'b0; div4_q <= 1'b0; if_q <= 1'b0; pcnt <= '0;
      dcnt <= '0; sat <= 1'b0;
      result <= '0; result_valid <= 1'b0; overflow <= 1'b0;
    end else begin
      if_q         <= if_in;
      result_valid <= 1'b0;
      if (!enable) begin
        st <= S_IDLE;
      end else if (st == S_IDLE) begin
        st   <= S_WAIT;
        scnt <= '0;
      end else if (open_now) begin
        st     <= S_GATE;
        tcnt   <= '0;
        tlen   <= sel_len;
        fm_q   <= fm_mode;
        div4_q <= pre_sel;
        pcnt   <= '0;
        dcnt   <= '0;
        sat    <= 1'b0;
        if (close) begin
          result       <= dnext;
          overflow     <= snext;
          result_valid <= 1'b1;
        end
      end else if (st == S_WAIT) begin
        if (ref_tick) scnt <= scnt + 1'b1;
      end else begin
        if (ref_tick) tcnt <= tcnt + 1'b1;
        if (rise && fm_q) pcnt <= (pcnt == pmax) ? 2'd0 : pcnt + 1'b1;
        dcnt <= dnext;
        sat  <= snext;
      end
    end
  end

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  a_r5_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(result));
  a_r10_no_strobe_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !result_valid);
  a_r8_overflow_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (&result));
endmodule

// File: tb/tb_if_gate_counter.sv
module tb_if_gate_counter;
  logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0, if_in = 1'b0;
  logic enable = 1'b0, fm_mode = 1'b0, pre_sel = 1'b0;
  logic [1:0] gate_sel = 2'b00;
  logic [15:0] result;
  logic [3:0]  result_n;
  logic result_valid, overflow, valid_n, overflow_n;

  int checks = 0, fails = 0, cyc = 0, tick_per = 1, tick_ph = 0;

  always #2.5 clk = ~clk;

  if_gate_counter dut (.clk, .rst_n, .ref_tick, .if_in, .enable, .fm_mode,
    .gate_sel, .pre_sel, .result, .result_valid, .overflow);
  if_gate_counter #(.CNT_W(4)) dut_n (.clk, .rst_n, .ref_tick, .if_in, .enable,
    .fm_mode, .gate_sel, .pre_sel, .result(result_n), .result_valid(valid_n),
    .overflow(overflow_n));

  always @(negedge clk) begin
    if (tick_ph >= tick_per - 1) begin tick_ph = 0; ref_tick = 1'b1; end
    else begin tick_ph++; ref_tick = 1'b0; end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<195000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wait_valid(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!result_valid && n < 20000);
  endtask

  task automatic inject(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk) if_in = 1'b1;
      @(negedge clk) if_in = 1'b0;
    end
  endtask

  function automatic int expect_cnt(input bit fm, input bit p4, input int k);
    return fm ? (p4 ? k / 4 : k / 2) : k;
  endfunction

  function automatic int gate_len(input logic [1:0] s);
    case (s) 2'b00: return 100; 2'b01: return 200; 2'b10: return 400; default: return 1000; endcase
  endfunction

  task automatic measure(input bit fm, input bit p4, input logic [1:0] gs, input int k,
                         input string req);
    int n;
    fm_mode = fm; pre_sel = p4; gate_sel = gs;
    wait_valid(n); wait_valid(n);
    repeat (2) @(negedge clk);
    inject(k);
    wait_valid(n);
    chk(result == 16'(expect_cnt(fm, p4, k)), req, result, expect_cnt(fm, p4, k));
  endtask

  initial begin
    int n;
    logic [15:0] held;
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    chk(result == 0 && !result_valid && !overflow, "R1", result, 0);
    rst_n = 1'b1;
    @(negedge clk);

    enable = 1'b1;
    wait_valid(n);
    chk(n == 106, "R7 first strobe", n, 106);

    for (int s = 0; s < 4; s++) begin
      gate_sel = 2'(s);
      wait_valid(n); wait_valid(n);
      chk(n == gate_len(2'(s)), "R2 gate spacing", n, gate_len(2'(s)));
    end
    tick_per = 3; gate_sel = 2'b00;
    wait_valid(n); wait_valid(n); wait_valid(n);
    chk(n == 300, "R2 sparse ticks", n, 300);
    tick_per = 1;
    wait_valid(n); wait_valid(n);

    measure(1'b0, 1'b0, 2'b00, 37, "R4 AM count");
    measure(1'b1, 1'b0, 2'b00, 37, "R3 FM div2");
    measure(1'b1, 1'b1, 2'b00, 37, "R3 FM div4");
    measure(1'b1, 1'b1, 2'b00, 3,  "R3 FM div4 below one");
    measure(1'b0, 1'b0, 2'b00, 25, "R6 setup");
    wait_valid(n);
    chk(result == 0, "R6 restart from zero", result, 0);

    measure(1'b0, 1'b0, 2'b00, 20, "R8 wide no overflow");
    chk(result_n == 4'hF && overflow_n, "R8 saturate", result_n, 15);
    chk(!overflow, "R8 wide flag", overflow, 0);
    measure(1'b0, 1'b0, 2'b00, 3, "R8 recover");
    chk(result_n == 4'd3 && !overflow_n, "R8 flag clears", {overflow_n, result_n}, 3);

    for (int i = 0; i < 20; i++)
      measure(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              2'($urandom_range(0, 1)), int'($urandom_range(0, 45)), "R3/R4 random");

    gate_sel = 2'b00;
    wait_valid(n); wait_valid(n);
    gate_sel = 2'b01;
    wait_valid(n);
    chk(n == 100, "R9 old gate kept", n, 100);
    wait_valid(n);
    chk(n == 200, "R9 new gate applied", n, 200);
    fm_mode = 1'b0;
    wait_valid(n);
    repeat (2) @(negedge clk);
    fm_mode = 1'b1; pre_sel = 1'b1;
    inject(20);
    wait_valid(n);
    chk(result == 20, "R9 mode held mid-gate", result, 20);

    gate_sel = 2'b00;
    wait_valid(n); wait_valid(n);
    repeat (10) @(negedge clk);
    enable = 1'b0;
    held = result;
    n = 0;
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (result_valid) n++;
      if (i == 50) inject(10);
    end
    chk(n == 0, "R10 no strobe", n, 0);
    chk(result == held, "R10 result kept", result, held);
    enable = 1'b1;
    wait_valid(n);
    chk(n == 106, "R10 restart delay", n, 106);
    wait_valid(n);
    chk(n == 100, "R5 spacing after restart", n, 100);
    @(negedge clk);
    chk(!result_valid, "R5 one-cycle strobe", result_valid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule